// File: doc/BRIEF.md
# Mode-Configurable Registered Bidirectional Transfer Register

This block models an eight-channel bidirectional transfer register with one storage element per direction. The transmit direction carries digital-side data toward the bus. The receive direction carries bus data, or internally looped data, back toward the digital side. Each direction has its own strobe input and its own 2-bit mode field. The mode field turns that direction's element into a plain buffer, an edge-captured register, or a transparent latch. All channels share the controls, so every channel switches in the same cycle.

Each output side is a data/enable pair for a pad: the enable flag says whether the pad drives, and the data reads zero while it does not. The storage elements keep working while their outputs are off.

Two loopback paths are provided. The digital loopback sends the transmit element's output through the receive element to the receive outputs, with the bus driver allowed to stay on at the same time. The bus loopback latches incoming bus data and drives it back out onto the bus.

Everything is synchronous to one system clock. A strobe is a level that is sampled on that clock: a rising strobe is one that is high at a clock edge after being low at the previous edge.

Top module: `xfer_transceiver`

## Requirements
- R1: A synchronous reset clears both stored words. After reset, a direction in register mode (01) presents 0.
- R2: With mode 00 a direction is a buffer: its output equals its input in the same cycle.
- R3: With mode 01 a direction loads its input at a clock edge where its own strobe is high and was low at the previous edge. Between such loads the output holds. The other direction's strobe has no effect on it.
- R4: With mode 10 a direction is a latch. While its strobe is high the output equals the input and the input is stored. While the strobe is low the output holds the last stored value.
- R5: With `bus_drv_en` low, `bus_oe` is 0 and `bus_out` is 0. With `dig_oe` low, `rx_oe` is 0 and `rx_data` is 0. A high enable raises the flag and presents the element output.
- R6: Both elements keep loading and holding while their output enables are low. A value captured while disabled appears once the enable returns.
- R7: With `dig_loop` high, and outside bus loopback, the receive element takes the transmit element's output as its input. `tx_data` then reaches `rx_data` through both elements in their configured modes.
- R8: During the digital loopback the bus driver keeps working, so `bus_out` shows the transmit element output while `rx_data` shows the looped data.
- R9: With `dig_loop` low and `rcv_off` high, the receive element input is forced to 0 whatever `bus_in` carries.
- R10: When all four mode bits are 1, both elements act as latches. The receive latch (`rx_strobe`) takes `bus_in`, or 0 if `rcv_off` is high. The transmit latch (`tx_strobe`) takes the receive latch output, and `bus_out` drives it. In this mode `tx_data` and `dig_loop` are ignored.
- R11: A mode field of 11 in only one direction makes that direction a plain latch fed from its normal input. No bus loopback happens.
- R12: Changing a mode field never alters a stored word. A value captured in register mode is still presented after a spell in buffer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | W | Digital-side data into the transmit element |
| tx_mode | input | 2 | Transmit element kind: 00 buffer, 01 register, 10 latch, 11 latch or bus loopback |
| tx_strobe | input | 1 | Transmit capture strobe / latch enable |
| rx_mode | input | 2 | Receive element kind, same encoding |
| rx_strobe | input | 1 | Receive capture strobe / latch enable |
| bus_in | input | W | Data seen on the bus pads |
| bus_out | output | W | Data driven onto the bus, 0 when not driving |
| bus_oe | output | 1 | Bus pad drive enable |
| bus_drv_en | input | 1 | Bus side output enable |
| rx_data | output | W | Receive data to the digital side, 0 when not driving |
| rx_oe | output | 1 | Receive pad drive enable |
| dig_oe | input | 1 | Digital side output enable |
| rcv_off | input | 1 | Bus receiver disable; forces receive source to 0 |
| dig_loop | input | 1 | Digital loopback select |

## Verification
The bench goes after the register mode's edge rule. A strobe held high must not load a second time, and a design that loads on the level would show the newer word one cycle early. It checks that the two strobes are independent, since a shared strobe would load the receive word when only the transmit strobe rises. It captures data while both enables are off and confirms the word appears on re-enable, which catches storage gated by the enable. It also exercises bus loopback with a stale receive latch, a one-sided 11 mode, and a return from buffer mode. A design that fed the loop from `tx_data`, entered bus loopback on one 11 field, or let buffer mode overwrite storage would present the wrong word.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    EK_BUF = 2'd0,
    EK_FF  = 2'd1,
    EK_LAT = 2'd2
  } elem_kind_e;

  // 00 buffer, 01 register, 10 and 11 latch
  function automatic elem_kind_e kind_of(input logic [1:0] m);
    case (m)
      2'b00:   kind_of = EK_BUF;
      2'b01:   kind_of = EK_FF;
      default: kind_of = EK_LAT;
    endcase
  endfunction

  // Element output as seen downstream of its storage word
  function automatic logic [63:0] elem_view(input elem_kind_e k, input logic strobe,
                                            input logic [63:0] d, input logic [63:0] held);
    case (k)
      EK_BUF:  elem_view = d;
      EK_FF:   elem_view = held;
      default: elem_view = strobe ? d : held;
    endcase
  endfunction

endpackage

// File: rtl/xfer_mode_dec.sv
module xfer_mode_dec
  import xfer_pkg::*;
(
  input  logic [1:0] tx_mode,
  input  logic [1:0] rx_mode,
  output elem_kind_e tx_kind,
  output elem_kind_e rx_kind,
  output logic       bus_loop
);
  always_comb begin
    tx_kind  = kind_of(tx_mode);
    rx_kind  = kind_of(rx_mode);
    bus_loop = &{tx_mode, rx_mode};
  end
endmodule

// File: rtl/xfer_cell.sv
module xfer_cell
  import xfer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  elem_kind_e   kind,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] held
);
  logic         strobe_q;
  logic         load;
  logic [W-1:0] word_q;

  always_comb begin
    case (kind)
      EK_FF:   load = strobe & ~strobe_q;
      EK_LAT:  load = strobe;
      default: load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      word_q   <= '0;
    end else begin
      strobe_q <= strobe;
      if (load) word_q <= d;
    end
  end

  assign held = word_q;
endmodule

// File: rtl/xfer_transceiver.sv
module xfer_transceiver
  import xfer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tx_data,
  input  logic [1:0]   tx_mode,
  input  logic         tx_strobe,
  input  logic [1:0]   rx_mode,
  input  logic         rx_strobe,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  input  logic         bus_drv_en,
  output logic [W-1:0] rx_data,
  output logic         rx_oe,
  input  logic         dig_oe,
  input  logic         rcv_off,
  input  logic         dig_loop
);
  localparam int VW = 64;

  elem_kind_e   tx_kind, rx_kind;
  logic         bus_loop;
  logic [W-1:0] tx_d, tx_held, tx_q;
  logic [W-1:0] rx_d, rx_held, rx_q;
  logic [W-1:0] bus_src, loop_node;
  logic [VW-1:0] tx_view, rx_view, loop_view;

  xfer_mode_dec u_dec (
    .tx_mode (tx_mode),
    .rx_mode (rx_mode),
    .tx_kind (tx_kind),
    .rx_kind (rx_kind),
    .bus_loop(bus_loop)
  );

  xfer_cell #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .kind(tx_kind), .strobe(tx_strobe), .d(tx_d), .held(tx_held)
  );

  xfer_cell #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .kind(rx_kind), .strobe(rx_strobe), .d(rx_d), .held(rx_held)
  );

  always_comb begin
    bus_src   = rcv_off ? '0 : bus_in;
    // bus loopback: receive latch view built from its stored word, no path through tx
    loop_view = elem_view(EK_LAT, rx_strobe, VW'(bus_src), VW'(rx_held));
    loop_node = loop_view[W-1:0];
    tx_d      = bus_loop ? loop_node : tx_data;
    tx_view   = elem_view(tx_kind, tx_strobe, VW'(tx_d), VW'(tx_held));
    tx_q      = tx_view[W-1:0];
    rx_d      = (dig_loop && !bus_loop) ? tx_q : bus_src;
    rx_view   = elem_view(rx_kind, rx_strobe, VW'(rx_d), VW'(rx_held));
    rx_q      = rx_view[W-1:0];
  end

  assign bus_oe  = bus_drv_en;
  assign bus_out = bus_drv_en ? tx_q : '0;
  assign rx_oe   = dig_oe;
  assign rx_data = dig_oe ? rx_q : '0;
endmodule

// File: rtl/xfer_transceiver_chk.sv
module xfer_transceiver_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] tx_data,
  input logic [1:0]   tx_mode,
  input logic [1:0]   rx_mode,
  input logic         tx_strobe,
  input logic         bus_drv_en,
  input logic         dig_oe,
  input logic         dig_loop,
  input logic [W-1:0] bus_out,
  input logic [W-1:0] rx_data,
  input logic         bus_oe,
  input logic         rx_oe
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (tx_mode != 2'b01 || bus_out == '0));

  assert_buf_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_mode == 2'b00 && bus_drv_en) |-> bus_out == tx_data);

  assert_ff_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_mode == 2'b01 && tx_strobe && !$past(tx_strobe))
      |=> (tx_mode != 2'b01 || !bus_drv_en || bus_out == $past(tx_data)));

  assert_ff_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_mode == 2'b01 && !tx_strobe && bus_drv_en)
      |=> (tx_mode != 2'b01 || !bus_drv_en || $stable(bus_out)));

  assert_lat_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_mode == 2'b10 && tx_strobe && bus_drv_en) |-> bus_out == tx_data);

  assert_lat_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_mode == 2'b10 && !tx_strobe && bus_drv_en)
      |=> (tx_mode != 2'b10 || tx_strobe || !bus_drv_en || $stable(bus_out)));

  assert_bus_off_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_drv_en |-> (!bus_oe && bus_out == '0));

  assert_dig_off_R5: assert property (@(posedge clk) disable iff (rst)
    !dig_oe |-> (!rx_oe && rx_data == '0));

  assert_loop_buf_R7: assert property (@(posedge clk) disable iff (rst)
    (dig_loop && tx_mode == 2'b00 && rx_mode == 2'b00 && dig_oe) |-> rx_data == tx_data);
endmodule

bind xfer_transceiver xfer_transceiver_chk #(.W(W)) u_chk (.*);

// File: tb/xfer_transceiver_tb.sv
module xfer_transceiver_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] tx_data = '0, bus_in = '0;
  logic [1:0] tx_mode = 2'b00, rx_mode = 2'b00;
  logic tx_strobe = 1'b0, rx_strobe = 1'b0;
  logic bus_drv_en = 1'b1, dig_oe = 1'b1, rcv_off = 1'b0, dig_loop = 1'b0;
  logic [W-1:0] bus_out, rx_data;
  logic bus_oe, rx_oe;

  always #5 clk = ~clk;

  xfer_transceiver #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_mode(tx_mode), .tx_strobe(tx_strobe),
    .rx_mode(rx_mode), .rx_strobe(rx_strobe), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .bus_drv_en(bus_drv_en), .rx_data(rx_data), .rx_oe(rx_oe),
    .dig_oe(dig_oe), .rcv_off(rcv_off), .dig_loop(dig_loop)
  );

  typedef struct {
    string        tag;
    logic [W-1:0] bus_out;
    logic         bus_oe;
    logic [W-1:0] rx_data;
    logic         rx_oe;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [W-1:0] m_txh = '0, m_rxh = '0;
  logic m_txs = 1'b0, m_rxs = 1'b0;

  function automatic int kind_of(input logic [1:0] m);
    return (m == 2'b00) ? 0 : (m == 2'b01) ? 1 : 2;
  endfunction

  function automatic logic [W-1:0] eout(input int k, input logic s,
                                        input logic [W-1:0] d, input logic [W-1:0] h);
    if (k == 0) return d;
    if (k == 1) return h;
    return s ? d : h;
  endfunction

  task automatic eval(output logic [W-1:0] txd, output logic [W-1:0] txq,
                      output logic [W-1:0] rxd, output logic [W-1:0] rxq);
    logic bl;
    logic [W-1:0] src;
    bl  = (tx_mode == 2'b11) && (rx_mode == 2'b11);
    src = rcv_off ? '0 : bus_in;
    if (bl) begin
      rxd = src;
      rxq = eout(2, rx_strobe, rxd, m_rxh);
      txd = rxq;
      txq = eout(2, tx_strobe, txd, m_txh);
    end else begin
      txd = tx_data;
      txq = eout(kind_of(tx_mode), tx_strobe, txd, m_txh);
      rxd = dig_loop ? txq : src;
      rxq = eout(kind_of(rx_mode), rx_strobe, rxd, m_rxh);
    end
  endtask

  // driver: inputs already set at a falling edge; predict the post-edge outputs
  task automatic step(input string tag);
    logic [W-1:0] txd, txq, rxd, rxq;
    int tk, rk;
    exp_t e;
    eval(txd, txq, rxd, rxq);
    tk = kind_of(tx_mode);
    rk = kind_of(rx_mode);
    if ((tk == 1 && tx_strobe && !m_txs) || (tk == 2 && tx_strobe)) m_txh = txd;
    if ((rk == 1 && rx_strobe && !m_rxs) || (rk == 2 && rx_strobe)) m_rxh = rxd;
    m_txs = tx_strobe;
    m_rxs = rx_strobe;
    eval(txd, txq, rxd, rxq);
    e.tag     = tag;
    e.bus_oe  = bus_drv_en;
    e.bus_out = bus_drv_en ? txq : '0;
    e.rx_oe   = dig_oe;
    e.rx_data = dig_oe ? rxq : '0;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(bus_out === e.bus_out, e.tag, "bus_out", bus_out, e.bus_out);
      check(bus_oe === e.bus_oe, e.tag, "bus_oe", W'(bus_oe), W'(e.bus_oe));
      check(rx_data === e.rx_data, e.tag, "rx_data", rx_data, e.rx_data);
      check(rx_oe === e.rx_oe, e.tag, "rx_oe", W'(rx_oe), W'(e.rx_oe));
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state seen through register mode
    tx_mode = 2'b01; rx_mode = 2'b01;
    tx_data = 8'hA5; bus_in = 8'h5A;
    step("R1");

    // R2: buffer both ways
    tx_mode = 2'b00; rx_mode = 2'b00;
    for (int i = 0; i < 4; i++) begin
      tx_data = W'($urandom); bus_in = W'($urandom);
      step("R2");
    end

    // R3: edge capture, independent strobes
    tx_mode = 2'b01; rx_mode = 2'b01;
    tx_data = 8'h3C; tx_strobe = 1'b1; bus_in = 8'h77; step("R3");
    tx_data = 8'hC3; bus_in = 8'h88; step("R3");
    tx_strobe = 1'b0; tx_data = 8'h11; step("R3");
    tx_strobe = 1'b1; tx_data = 8'h96; step("R3");
    rx_strobe = 1'b1; bus_in = 8'hE1; step("R3");
    rx_strobe = 1'b0; tx_strobe = 1'b0; bus_in = 8'h02; step("R3");

    // R4: latch transparent then holding
    tx_mode = 2'b10; rx_mode = 2'b10;
    tx_strobe = 1'b1; rx_strobe = 1'b1;
    for (int i = 0; i < 2; i++) begin
      tx_data = W'($urandom); bus_in = W'($urandom);
      step("R4");
    end
    tx_strobe = 1'b0; rx_strobe = 1'b0;
    for (int i = 0; i < 2; i++) begin
      tx_data = W'($urandom); bus_in = W'($urandom);
      step("R4");
    end

    // R5 / R6: outputs off, storage still loads
    tx_mode = 2'b01; rx_mode = 2'b01;
    bus_drv_en = 1'b0; dig_oe = 1'b0; step("R5");
    tx_strobe = 1'b1; rx_strobe = 1'b1; tx_data = 8'h4B; bus_in = 8'hB4; step("R6");
    tx_strobe = 1'b0; rx_strobe = 1'b0; tx_data = 8'h00; bus_in = 8'hFF;
    bus_drv_en = 1'b1; dig_oe = 1'b1; step("R6");

    // R7 / R8: digital loopback with bus still driven
    dig_loop = 1'b1; rcv_off = 1'b1;
    tx_mode = 2'b00; rx_mode = 2'b00;
    for (int i = 0; i < 2; i++) begin
      tx_data = W'($urandom); bus_in = W'($urandom);
      step("R7 R8");
    end
    tx_mode = 2'b01; rx_mode = 2'b01;
    tx_data = 8'h69; tx_strobe = 1'b1; step("R7 R8");
    rx_strobe = 1'b1; tx_data = 8'h12; step("R7 R8");
    tx_strobe = 1'b0; rx_strobe = 1'b0;
    tx_mode = 2'b10; rx_mode = 2'b10;
    tx_strobe = 1'b1; rx_strobe = 1'b1; tx_data = 8'hD7; step("R7 R8");
    tx_strobe = 1'b0; rx_strobe = 1'b0; tx_data = 8'h28; step("R7 R8");

    // R9: receiver disabled
    dig_loop = 1'b0; rcv_off = 1'b1;
    tx_mode = 2'b00; rx_mode = 2'b00;
    bus_in = 8'hF0; step("R9");
    bus_in = 8'h0F; step("R9");

    // R10: bus loopback, dig_loop and tx_data ignored
    rcv_off = 1'b0; dig_loop = 1'b1;
    tx_mode = 2'b11; rx_mode = 2'b11;
    tx_strobe = 1'b1; rx_strobe = 1'b1; bus_in = 8'h9E; tx_data = 8'h01; step("R10");
    rx_strobe = 1'b0; tx_strobe = 1'b0; bus_in = 8'h44; tx_data = 8'h02; step("R10");
    rx_strobe = 1'b1; bus_in = 8'h5D; step("R10");
    tx_strobe = 1'b1; step("R10");
    tx_strobe = 1'b0; rx_strobe = 1'b0;

    // R11: one-sided 11 is a plain latch
    dig_loop = 1'b0; tx_mode = 2'b11; rx_mode = 2'b00;
    tx_strobe = 1'b1; tx_data = 8'hAB; bus_in = 8'hCD; step("R11");
    tx_strobe = 1'b0; tx_data = 8'h34; step("R11");

    // R12: mode swaps leave storage intact
    tx_mode = 2'b01; tx_strobe = 1'b1; tx_data = 8'h7E; step("R12");
    tx_strobe = 1'b0; tx_mode = 2'b00; tx_data = 8'h81; step("R12");
    tx_mode = 2'b01; tx_data = 8'h00; step("R12");

    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule